// File: doc/BRIEF.md
# Serial NOR Flash Modify-Command Sequencer

This block runs one flash-modifying operation (page program, sector or block erase, or any other opcode that takes an address) against a serial NOR flash. It reaches the flash through a byte-level SPI master port. A caller loads the payload into a small internal byte store, presents the opcode, the address, the payload length and a poll interval, and pulses `start`. The sequencer first sends a one-byte write-enable frame. It then sends the command frame: the opcode, the address, and the payload. Afterwards it reads the flash status register repeatedly until the busy bit drops. It finishes with a one-cycle `done` pulse and an error code.

The address is sent as four bytes when the opcode natively takes a 32-bit address or when the flash is in 32-bit address mode. Otherwise it is sent as three bytes. In the three-byte case, a flash that has an extended-address register gets its top address byte written there first, through its own write-enable and register-write frames. The sequencer keeps a copy of the last value it wrote successfully, and the register write is skipped when the requested top byte matches that copy. Some requests cannot be served: a 32-bit address on a master without 32-bit support, a nonzero top byte with no register to hold it, or a payload that is too long. These are refused before any frame is opened.

Top module: `flash_mod_seq`

## Requirements
- R1: Every modifying frame (the command frame and the extended-address register write) is preceded by its own frame holding only the byte 0x06. Chip-select (`spi_cs`, active high) drops for at least one cycle between any two frames.
- R2: When `op_native4` or `mode_4byte` is 1, the command frame is the opcode followed by address bits 31:24, 23:16, 15:8, 7:0. Otherwise it is the opcode followed by bits 23:16, 15:8, 7:0.
- R3: If a 4-byte address is needed and `feat_master4` is 0, the operation ends with `err_code` = 1 (refused) and no frame is opened.
- R4: In 3-byte mode with `feat_ear` = 1, the frames 0x06 and then {`ear_opcode`, address bits 31:24} precede the write-enable and command frames.
- R5: The extended-address write of R4 is skipped when address bits 31:24 equal the value from the last extended-address write that completed without a fault. After reset no value is held.
- R6: In 3-byte mode with `feat_ear` = 0, a nonzero address bits 31:24 gives `err_code` = 1 and no frame.
- R7: The command frame holds exactly 1 + address length + `op_len` bytes. The payload bytes are taken from store locations 0, 1, 2 … in order. An `op_len` above MAX_DATA (256) gives `err_code` = 1 and no frame. While a byte is waiting for `spi_ack`, `spi_req` and `spi_wdata` stay steady.
- R8: When `poll_gap` is nonzero, the command frame is followed by two-byte status frames {0x05, 0x00}, one per poll. Polling stops when bit 0 of the byte returned for the second position is 0. Between two status frames chip-select stays low for exactly `poll_gap` cycles. When `poll_gap` is 0, no status frame is sent.
- R9: If bit 0 is still 1 after POLL_MAX status frames, the operation ends with `err_code` = 3 (timeout).
- R10: A `spi_fault` reported with any byte of a write-enable, register-write or command frame gives `err_code` = 2. This takes precedence over a timeout, and polling still runs. A clean run gives `err_code` = 0.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | begin an operation (sampled when idle) |
| op_code | input | 8 | command opcode |
| op_native4 | input | 1 | opcode always takes a 4-byte address |
| mode_4byte | input | 1 | flash is in 4-byte address mode |
| op_addr | input | 32 | target address |
| op_len | input | LEN_W | payload byte count |
| poll_gap | input | GAP_W | idle cycles between status polls, 0 = no polling |
| feat_master4 | input | 1 | master can send 4-byte addresses |
| feat_ear | input | 1 | flash has an extended-address register |
| ear_opcode | input | 8 | opcode that writes the extended-address register |
| buf_we | input | 1 | payload store write strobe |
| buf_waddr | input | BUF_AW | payload store write location |
| buf_wdata | input | 8 | payload store write byte |
| spi_cs | output | 1 | frame open (chip-select asserted) |
| spi_req | output | 1 | a byte is offered to the master |
| spi_wdata | output | 8 | byte to shift out |
| spi_ack | input | 1 | master finished the offered byte |
| spi_rdata | input | 8 | byte shifted in, valid with `spi_ack` |
| spi_fault | input | 1 | master reports a transfer fault, valid with `spi_ack` |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 refused, 2 fault, 3 timeout; valid with `done` |

## Verification
The embedded properties check the following on every cycle: `done` is a single pulse; an offered byte holds steady until it is acknowledged; refused requests finish on the next cycle with code 1; the extended-address frame never appears when the held value already matches; and the wait state occurs only with a nonzero interval. Other behaviours can only be shown by the directed scenarios, which watch the frames on the master port. These include the byte order of 3- and 4-byte addresses, the write-enable framing, the skip-then-rewrite pattern of the register cache, the exact idle length between polls, the timeout count, and fault taking precedence over timeout.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam int         STATUS_BUSY_BIT = 0;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_REJECT  = 2'd1,
      ERR_FAULT   = 2'd2,
      ERR_TIMEOUT = 2'd3
   } seq_err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WEN,
      ST_EAR,
      ST_CMD,
      ST_POLL,
      ST_WAIT,
      ST_GAP,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/seq_byte_store.sv
module seq_byte_store #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/seq_frame_bytes.sv
module seq_frame_bytes
   import flash_seq_pkg::*;
#(
   parameter int IDX_W = 10,
   parameter int AW    = 8
) (
   input  seq_state_e       state,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       opcode,
   input  logic [31:0]      addr,
   input  logic             use4,
   input  logic [7:0]       ear_op,
   input  logic [7:0]       store_byte,
   output logic [AW-1:0]    store_raddr,
   output logic [7:0]       out_byte
);
   logic [7:0]       addr_b [4];
   logic [2:0]       sel;
   logic [IDX_W-1:0] alen;
   logic [IDX_W-1:0] off;

   for (genvar g = 0; g < 4; g++) begin : g_addr_bytes
      assign addr_b[g] = addr[31-8*g -: 8];
   end

   assign alen        = use4 ? IDX_W'(4) : IDX_W'(3);
   assign off         = idx - alen - IDX_W'(1);
   assign store_raddr = off[AW-1:0];
   assign sel         = use4 ? (idx[2:0] - 3'd1) : idx[2:0];

   always_comb begin
      out_byte = 8'h00;
      case (state)
         ST_WEN:  out_byte = OPC_WREN;
         ST_EAR:  out_byte = (idx == '0) ? ear_op : addr_b[0];
         ST_POLL: out_byte = (idx == '0) ? OPC_RDSR : 8'h00;
         ST_CMD: begin
            if (idx == '0)       out_byte = opcode;
            else if (idx <= alen) out_byte = addr_b[sel[1:0]];
            else                  out_byte = store_byte;
         end
         default: out_byte = 8'h00;
      endcase
   end
endmodule

// File: rtl/flash_mod_seq.sv
module flash_mod_seq
   import flash_seq_pkg::*;
#(
   parameter  int MAX_DATA = 256,
   parameter  int GAP_W    = 16,
   parameter  int POLL_MAX = 1000,
   localparam int BUF_AW   = $clog2(MAX_DATA),
   localparam int LEN_W    = BUF_AW + 2,
   localparam int IDX_W    = LEN_W,
   localparam int PC_W     = $clog2(POLL_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        op_code,
   input  logic              op_native4,
   input  logic              mode_4byte,
   input  logic [31:0]       op_addr,
   input  logic [LEN_W-1:0]  op_len,
   input  logic [GAP_W-1:0]  poll_gap,
   input  logic              feat_master4,
   input  logic              feat_ear,
   input  logic [7:0]        ear_opcode,
   input  logic              buf_we,
   input  logic [BUF_AW-1:0] buf_waddr,
   input  logic [7:0]        buf_wdata,
   output logic              spi_cs,
   output logic              spi_req,
   output logic [7:0]        spi_wdata,
   input  logic              spi_ack,
   input  logic [7:0]        spi_rdata,
   input  logic              spi_fault,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err_code
);
   if (MAX_DATA < 2 || (1 << BUF_AW) != MAX_DATA) begin : g_bad_depth
      $error("MAX_DATA must be a power of two of at least 2");
   end
   if (POLL_MAX < 1) begin : g_bad_polls
      $error("POLL_MAX must be at least 1");
   end
   if (GAP_W < 1) begin : g_bad_gap
      $error("GAP_W must be at least 1");
   end

   seq_state_e        state, after;
   logic [IDX_W-1:0]  idx, flen;
   logic [7:0]        op_r, ear_op_r, ear_val;
   logic [31:0]       addr_r;
   logic [LEN_W-1:0]  len_r;
   logic [GAP_W-1:0]  gap_r;
   logic [PC_W-1:0]   poll_cnt;
   logic              use4_r, ear_pend, ear_known, cmd_fault, timed_out, rej_r;
   logic              use4, ear_hit, reject, in_frame, last_byte, poll_again;
   logic              tmr_load, tmr_zero;
   logic [BUF_AW-1:0] st_raddr;
   logic [7:0]        st_rdata;

   assign use4    = op_native4 | mode_4byte;
   assign ear_hit = ear_known && (ear_val == op_addr[31:24]);
   assign reject  = (use4 && !feat_master4)
                 || (!use4 && !feat_ear && op_addr[31:24] != 8'h00)
                 || (op_len > LEN_W'(MAX_DATA));

   assign in_frame = (state == ST_WEN) || (state == ST_EAR)
                  || (state == ST_CMD) || (state == ST_POLL);

   always_comb begin
      case (state)
         ST_EAR, ST_POLL: flen = IDX_W'(2);
         ST_CMD:          flen = (use4_r ? IDX_W'(5) : IDX_W'(4)) + IDX_W'(len_r);
         default:         flen = IDX_W'(1);
      endcase
   end

   assign last_byte  = (idx == flen - IDX_W'(1));
   assign poll_again = spi_rdata[STATUS_BUSY_BIT] && (poll_cnt != PC_W'(POLL_MAX - 1));
   assign tmr_load   = (state == ST_POLL) && spi_ack && last_byte && poll_again;

   seq_byte_store #(.DEPTH(MAX_DATA), .AW(BUF_AW)) u_store (
      .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
      .raddr(st_raddr), .rdata(st_rdata));

   seq_gap_timer #(.W(GAP_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load),
      .load_val(gap_r - GAP_W'(1)), .zero(tmr_zero));

   seq_frame_bytes #(.IDX_W(IDX_W), .AW(BUF_AW)) u_bytes (
      .state(state), .idx(idx), .opcode(op_r), .addr(addr_r), .use4(use4_r),
      .ear_op(ear_op_r), .store_byte(st_rdata), .store_raddr(st_raddr),
      .out_byte(spi_wdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;   after <= ST_IDLE;  idx <= '0;
         op_r <= '0;         ear_op_r <= '0;    addr_r <= '0;
         len_r <= '0;        gap_r <= '0;       use4_r <= 1'b0;
         ear_pend <= 1'b0;   ear_known <= 1'b0; ear_val <= '0;
         cmd_fault <= 1'b0;  timed_out <= 1'b0; rej_r <= 1'b0;
         poll_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               op_r <= op_code;   ear_op_r <= ear_opcode; addr_r <= op_addr;
               len_r <= op_len;   gap_r <= poll_gap;      use4_r <= use4;
               cmd_fault <= 1'b0; timed_out <= 1'b0;      poll_cnt <= '0;
               idx <= '0;
               rej_r    <= reject;
               ear_pend <= !use4 && feat_ear && !ear_hit;
               state    <= reject ? ST_DONE : ST_WEN;
            end
            ST_WEN, ST_EAR, ST_CMD, ST_POLL: if (spi_ack) begin
               if (state != ST_POLL && spi_fault) cmd_fault <= 1'b1;
               if (!last_byte) begin
                  idx <= idx + 1'b1;
               end else begin
                  idx <= '0;
                  if (state == ST_WEN) begin
                     after <= ear_pend ? ST_EAR : ST_CMD;
                     state <= ST_GAP;
                  end else if (state == ST_EAR) begin
                     ear_pend <= 1'b0;
                     if (!cmd_fault && !spi_fault) begin
                        ear_known <= 1'b1;
                        ear_val   <= addr_r[31:24];
                     end
                     after <= ST_WEN;
                     state <= ST_GAP;
                  end else if (state == ST_CMD) begin
                     after <= ST_POLL;
                     state <= (gap_r != '0) ? ST_GAP : ST_DONE;
                  end else if (!spi_rdata[STATUS_BUSY_BIT]) begin
                     state <= ST_DONE;
                  end else if (!poll_again) begin
                     timed_out <= 1'b1;
                     state     <= ST_DONE;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                     state    <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: if (tmr_zero) state <= ST_POLL;
            ST_GAP:  state <= after;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs  = in_frame;
   assign spi_req = in_frame;
   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_DONE);

   always_comb begin
      err_code = ERR_NONE;
      if (done) begin
         if (rej_r)          err_code = ERR_REJECT;
         else if (cmd_fault) err_code = ERR_FAULT;
         else if (timed_out) err_code = ERR_TIMEOUT;
      end
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_req && !spi_ack) |=> (spi_req && $stable(spi_wdata)));

   assert_refuse_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && reject) |=> (done && err_code == ERR_REJECT));

   assert_ear_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EAR) |-> !(ear_known && ear_val == addr_r[31:24]));

   assert_wait_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (gap_r != '0));

endmodule

// File: tb/flash_mod_seq_bench.sv
module flash_mod_seq_bench;
   localparam int MAXD  = 256;
   localparam int AW    = 8;
   localparam int LW    = 10;
   localparam int GW    = 16;
   localparam int PMAX  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    op_code = '0;
   logic          op_native4 = 1'b0, mode_4byte = 1'b0;
   logic [31:0]   op_addr = '0;
   logic [LW-1:0] op_len = '0;
   logic [GW-1:0] poll_gap = '0;
   logic          feat_master4 = 1'b1, feat_ear = 1'b0;
   logic [7:0]    ear_opcode = 8'hC5;
   logic          buf_we = 1'b0;
   logic [AW-1:0] buf_waddr = '0;
   logic [7:0]    buf_wdata = '0;
   logic          spi_cs, spi_req, busy, done;
   logic [7:0]    spi_wdata;
   logic          spi_ack, spi_fault;
   logic [7:0]    spi_rdata;
   logic [1:0]    err_code;

   always #10 clk = ~clk;

   flash_mod_seq #(.MAX_DATA(MAXD), .GAP_W(GW), .POLL_MAX(PMAX)) u_flash_mod_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .op_native4(op_native4), .mode_4byte(mode_4byte), .op_addr(op_addr),
      .op_len(op_len), .poll_gap(poll_gap), .feat_master4(feat_master4),
      .feat_ear(feat_ear), .ear_opcode(ear_opcode), .buf_we(buf_we),
      .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .spi_cs(spi_cs),
      .spi_req(spi_req), .spi_wdata(spi_wdata), .spi_ack(spi_ack),
      .spi_rdata(spi_rdata), .spi_fault(spi_fault), .busy(busy),
      .done(done), .err_code(err_code));

   // master model and frame log
   logic [7:0] lbyte [2048];
   int         fstart [64];
   int         fgap [64];
   int         nb, nf, pos, wcnt, lowrun, lastlow;
   logic [7:0] first_b;
   logic       cs_q;
   logic       log_clr = 1'b0;
   int         busy_init = 0, fault_frame = -1, busy_left;

   always @(posedge clk) begin
      if (!rst_n || log_clr) begin
         spi_ack <= 1'b0; spi_fault <= 1'b0; spi_rdata <= 8'h00;
         nb <= 0; nf <= 0; pos <= 0; wcnt <= 0; lowrun <= 0; lastlow <= 0;
         cs_q <= 1'b0; first_b <= 8'h00; busy_left <= busy_init;
      end else begin
         cs_q <= spi_cs;
         if (!spi_cs) begin
            lowrun <= lowrun + 1;
            pos <= 0;
         end else if (!cs_q) begin
            lastlow <= lowrun;
            lowrun <= 0;
         end
         spi_fault <= 1'b0;
         if (spi_req && !spi_ack) begin
            if (wcnt == 1) begin
               wcnt <= 0;
               spi_ack <= 1'b1;
               lbyte[nb] <= spi_wdata;
               nb <= nb + 1;
               pos <= pos + 1;
               spi_rdata <= 8'h00;
               if (pos == 0) begin
                  fstart[nf] <= nb;
                  fgap[nf] <= lastlow;
                  nf <= nf + 1;
                  first_b <= spi_wdata;
                  if (fault_frame == nf) spi_fault <= 1'b1;
               end else begin
                  if (fault_frame == nf - 1) spi_fault <= 1'b1;
                  if (pos == 1 && first_b == 8'h05) begin
                     spi_rdata <= {7'b0, busy_left > 0};
                     if (busy_left > 0) busy_left <= busy_left - 1;
                  end
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end else begin
            spi_ack <= 1'b0;
            wcnt <= 0;
         end
      end
   end

   int errors = 0, checks = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   function automatic int flen(input int f);
      return (f + 1 < nf) ? fstart[f+1] - fstart[f] : nb - fstart[f];
   endfunction

   function automatic logic [7:0] fb(input int f, input int k);
      return lbyte[fstart[f] + k];
   endfunction

   logic [1:0] res_code;
   logic       res_busy, res_done_after;

   task automatic run_op(input logic [7:0] op, input logic n4, input logic m4,
                         input logic [31:0] a, input int len, input int gap);
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      op_code = op; op_native4 = n4; mode_4byte = m4; op_addr = a;
      op_len = LW'(len); poll_gap = GW'(gap); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      res_busy = busy;
      while (!done) @(negedge clk);
      res_code = err_code;
      @(negedge clk);
      res_done_after = done;
   endtask

   task automatic fill_store();
      for (int i = 0; i < MAXD; i++) begin
         @(negedge clk);
         buf_we = 1'b1; buf_waddr = AW'(i); buf_wdata = pat(i);
      end
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic t_reset();
      chk(busy == 1'b0 && done == 1'b0, "R11 reset idle", {busy, done}, 0);
      chk(spi_cs == 1'b0 && spi_req == 1'b0, "R1 reset cs low", {spi_cs, spi_req}, 0);
   endtask

   task automatic t_prog3();
      feat_ear = 1'b0; feat_master4 = 1'b1; busy_init = 2; fault_frame = -1;
      run_op(8'h02, 1'b0, 1'b0, 32'h0012_3456, 3, 3);
      chk(res_busy == 1'b1, "R11 busy after start", res_busy, 1);
      chk(res_done_after == 1'b0, "R11 done single pulse", res_done_after, 0);
      chk(res_code == 2'd0, "R10 clean code", res_code, 0);
      chk(nf == 5, "R8 frame count with two busy polls", nf, 5);
      chk(flen(0) == 1 && fb(0, 0) == 8'h06, "R1 write-enable frame", fb(0, 0), 8'h06);
      chk(flen(1) == 7, "R7 command length 1+3+3", flen(1), 7);
      chk({fb(1,0), fb(1,1), fb(1,2), fb(1,3)} == 32'h0212_3456, "R2 three-byte address order",
          {fb(1,0), fb(1,1), fb(1,2), fb(1,3)}, 32'h0212_3456);
      chk({fb(1,4), fb(1,5), fb(1,6)} == {pat(0), pat(1), pat(2)}, "R7 payload order",
          {fb(1,4), fb(1,5), fb(1,6)}, {pat(0), pat(1), pat(2)});
      chk(flen(2) == 2 && fb(2, 0) == 8'h05 && fb(2, 1) == 8'h00, "R8 status frame",
          {fb(2,0), fb(2,1)}, 16'h0500);
      chk(fgap[3] == 3 && fgap[4] == 3, "R8 poll interval", fgap[3], 3);
   endtask

   task automatic t_native4();
      busy_init = 0;
      run_op(8'h12, 1'b1, 1'b0, 32'hAB12_3456, 0, 0);
      chk(res_code == 2'd0, "R2 native code", res_code, 0);
      chk(nf == 2, "R8 zero interval no polling", nf, 2);
      chk(flen(1) == 5 && {fb(1,1), fb(1,2), fb(1,3), fb(1,4)} == 32'hAB12_3456,
          "R2 four-byte address order", {fb(1,1), fb(1,2), fb(1,3), fb(1,4)}, 32'hAB12_3456);
   endtask

   task automatic t_refuse();
      feat_master4 = 1'b0;
      run_op(8'h12, 1'b1, 1'b0, 32'h0000_0010, 0, 0);
      chk(res_code == 2'd1 && nf == 0, "R3 no 4-byte master", {res_code, 8'(nf)}, 10'h100);
      feat_master4 = 1'b1; feat_ear = 1'b0;
      run_op(8'h02, 1'b0, 1'b0, 32'h0100_0000, 0, 0);
      chk(res_code == 2'd1 && nf == 0, "R6 high byte without register", {res_code, 8'(nf)}, 10'h100);
      run_op(8'h02, 1'b0, 1'b0, 32'h0000_0000, 257, 0);
      chk(res_code == 2'd1 && nf == 0, "R7 over-length refused", {res_code, 8'(nf)}, 10'h100);
   endtask

   task automatic t_full_page();
      int bad = 0;
      run_op(8'h02, 1'b0, 1'b0, 32'h0000_0100, 256, 0);
      chk(res_code == 2'd0 && flen(1) == 260, "R7 full payload length", flen(1), 260);
      for (int i = 0; i < 256; i++) if (fb(1, 4 + i) != pat(i)) bad++;
      chk(bad == 0, "R7 full payload bytes", bad, 0);
   endtask

   task automatic t_ear();
      feat_ear = 1'b1;
      run_op(8'h20, 1'b0, 1'b0, 32'h0500_1000, 0, 0);
      chk(nf == 4, "R4 register write frames", nf, 4);
      chk(flen(1) == 2 && fb(1,0) == 8'hC5 && fb(1,1) == 8'h05, "R4 register frame bytes",
          {fb(1,0), fb(1,1)}, 16'hC505);
      chk(fb(0,0) == 8'h06 && fb(2,0) == 8'h06 && flen(2) == 1, "R1 enable before each",
          {fb(0,0), fb(2,0)}, 16'h0606);
      chk({fb(3,0), fb(3,1), fb(3,2), fb(3,3)} == 32'h2000_1000, "R2 low bytes after register",
          {fb(3,0), fb(3,1), fb(3,2), fb(3,3)}, 32'h2000_1000);
      run_op(8'h20, 1'b0, 1'b0, 32'h05FF_FFF0, 0, 0);
      chk(nf == 2 && fb(1,0) == 8'h20, "R5 cached value skips write", nf, 2);
      run_op(8'h20, 1'b0, 1'b0, 32'h0700_0000, 0, 0);
      chk(nf == 4 && fb(1,1) == 8'h07, "R5 new value rewrites", {8'(nf), fb(1,1)}, 16'h0407);
      mode_4byte = 1'b1;
      run_op(8'h02, 1'b0, 1'b1, 32'h0900_0010, 0, 0);
      chk(nf == 2 && flen(1) == 5 && fb(1,1) == 8'h09, "R2 mode flag four bytes no register",
          {8'(nf), 8'(flen(1))}, 16'h0205);
      feat_ear = 1'b0;
   endtask

   task automatic t_timeout_fault();
      busy_init = 100; fault_frame = -1;
      run_op(8'h02, 1'b0, 1'b0, 32'h0000_0000, 0, 2);
      chk(res_code == 2'd3, "R9 timeout code", res_code, 3);
      chk(nf == 2 + PMAX, "R9 poll count", nf, 2 + PMAX);
      fault_frame = 1;
      run_op(8'h02, 1'b0, 1'b0, 32'h0000_0000, 0, 2);
      chk(res_code == 2'd2, "R10 fault beats timeout", res_code, 2);
      chk(nf == 2 + PMAX, "R10 polling still runs", nf, 2 + PMAX);
      busy_init = 0; fault_frame = 0;
      run_op(8'h02, 1'b0, 1'b0, 32'h0000_0000, 0, 2);
      chk(res_code == 2'd2 && nf == 3, "R10 enable fault", {res_code, 8'(nf)}, 10'h203);
      fault_frame = -1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      fill_store();
      t_prog3();
      t_native4();
      t_refuse();
      t_full_page();
      t_ear();
      t_timeout_fault();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d expected=0", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule